// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache

This block is a small translation cache built from flip-flops. It sits in front of a larger set-associative main TLB. A lookup presents a virtual page number and an 8-bit address-space identifier (ASID). Every stored entry is compared in parallel. On a hit, the physical frame number and the stored permission flags come back in the same cycle. The block does not check permissions; it only returns the stored flags.

On a miss, the block stalls the lookup and sends a refill request to the main TLB. It then installs the returned entry:
- into a free way, if one exists;
- otherwise into the way chosen by a tree pseudo-LRU.

If the main TLB reports that no translation exists, the block returns a fault for that lookup and installs nothing.

The block's entries are not tied to the main TLB's entries. A main-TLB write that only replaces a victim leaves this cache untouched, so its higher associativity can hide the main TLB's set conflicts. Only a flushing main-TLB write or an explicit invalidate command clears the cache. The block is instantiated with 8 ways for data accesses and with 4 ways for instruction fetch.

Back-pressure rules:
- The lookup and refill-request ports are valid/ready. A requester holds valid and its payload stable until ready is seen high at a clock edge.
- The result is qualified by `res_valid`, which is high exactly in the cycle the lookup is accepted. The result cannot be stalled.
- The refill response has no ready. It is taken in any cycle where the block is waiting for it and is ignored at all other times.

Top module: `utlb`

## Requirements
- R1: A lookup whose page and ASID match a valid entry is accepted in the same cycle. In that cycle `lk_ready` and `res_valid` are 1, `res_fault` is 0, and `res_pfn`/`res_flags` carry the stored values.
- R2: An entry installed with its global bit set matches on page number alone, for any ASID. A non-global entry does not match a lookup with a different ASID.
- R3: On a miss, `lk_ready` stays 0. From the next cycle `rf_req_valid` is 1 with the lookup's page and ASID, held stable until `rf_req_ready`. The lookup stays stalled until the response.
- R4: After a successful refill the lookup hits in the following cycle. While any way is invalid, an install never replaces a valid entry.
- R5: With all ways valid, the victim is the way named by a binary-tree pseudo-LRU. Each tree node is updated, on every hit and every install, to point away from the accessed way.
- R6: `mt_cmd` code 1 (flushing write) invalidates every entry by the next cycle.
- R7: `mt_cmd` code 2 (write without invalidate), code 0 and codes 4 to 7 leave every entry untouched.
- R8: `mt_cmd` code 3 (explicit invalidate) invalidates every entry by the next cycle, whatever the refill state.
- R9: An invalidate (code 1 or 3) in any cycle from the miss up to and including the response cycle causes the response to be discarded. Nothing is installed, no result is given, and the held lookup starts a new refill.
- R10: A refill response with `rf_rsp_fault`=1 completes the lookup in that cycle with `res_valid`=1 and `res_fault`=1, and installs nothing.
- R11: After reset no entry is valid and `rf_req_valid`, `lk_ready` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| res_valid | output | 1 | Result valid (equals acceptance) |
| res_fault | output | 1 | Translation fault result |
| res_pfn | output | PFN_W | Physical frame number on hit |
| res_flags | output | FLAG_W | Stored permission flags on hit |
| rf_req_valid | output | 1 | Refill request valid |
| rf_req_ready | input | 1 | Main TLB accepts the refill request |
| rf_req_vpn | output | VPN_W | Page number to refill |
| rf_req_asid | output | ASID_W | ASID to refill |
| rf_rsp_valid | input | 1 | Refill response valid |
| rf_rsp_fault | input | 1 | Main TLB has no translation |
| rf_rsp_pfn | input | PFN_W | Returned frame number |
| rf_rsp_flags | input | FLAG_W | Returned permission flags |
| rf_rsp_global | input | 1 | Returned entry ignores ASID |
| mt_cmd | input | 3 | Main-TLB command code (0 none, 1 flushing write, 2 non-invalidating write, 3 invalidate) |

## Verification
The bench builds the 4-way instruction variant with 20-bit page and frame numbers and 8-bit ASIDs. With only four ways, a short fill sequence makes every way valid, so the pseudo-LRU victim choice can be observed through which page starts missing again. That same small configuration also lets the bench set up a refill that is cut off by an invalidate within a few cycles.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic [2:0] {
    MC_NONE       = 3'd0,
    MC_WR_FLUSH   = 3'd1,
    MC_WR_KEEP    = 3'd2,
    MC_INVALIDATE = 3'd3
  } mt_cmd_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fsm_state_e;

  function automatic logic cmd_clears(input logic [2:0] c);
    return (c == MC_WR_FLUSH) || (c == MC_INVALIDATE);
  endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]        ent_valid,
  input  logic [WAYS-1:0]        ent_global,
  input  logic [WAYS*VPN_W-1:0]  ent_vpn,
  input  logic [WAYS*ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]       q_vpn,
  input  logic [ASID_W-1:0]      q_asid,
  output logic [WAYS-1:0]        hit_vec,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    logic page_eq, space_eq;
    assign page_eq    = (ent_vpn[g*VPN_W +: VPN_W] == q_vpn);
    assign space_eq   = ent_global[g] || (ent_asid[g*ASID_W +: ASID_W] == q_asid);
    assign hit_vec[g] = ent_valid[g] && page_eq && space_eq;
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/utlb_plru.sv
module utlb_plru #(
  parameter int WAYS   = 8,
  localparam int IDX_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  // Heap-ordered tree: node n (1-based) stored at bit n-1.
  // A node bit of 0 names its left subtree as least recently used.
  logic [NODES-1:0] tree_q, tree_nx;

  always_comb begin
    int n;
    n = 1;
    for (int l = 0; l < IDX_W; l++) begin
      n = 2 * n + (tree_q[n-1] ? 1 : 0);
    end
    victim_idx = IDX_W'(n - WAYS);
  end

  always_comb begin
    int node;
    tree_nx = tree_q;
    node = int'(touch_idx) + WAYS;
    for (int l = 0; l < IDX_W; l++) begin
      tree_nx[(node / 2) - 1] = ((node % 2) == 0);
      node = node / 2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     tree_q <= '0;
    else if (touch) tree_q <= tree_nx;
  end

endmodule

// File: rtl/utlb_fsm.sv
module utlb_fsm
  import utlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lk_valid,
  input  logic hit,
  input  logic flush,
  input  logic rf_req_ready,
  input  logic rf_rsp_valid,
  input  logic rf_rsp_fault,
  output logic rf_req_valid,
  output logic hit_acc,
  output logic start_miss,
  output logic install,
  output logic fault_rep,
  output logic busy
);

  fsm_state_e st_q, st_nx;
  logic       drop_q;
  logic       idle, rsp_take, stale;

  assign idle       = (st_q == FS_IDLE);
  assign busy       = !idle;
  assign hit_acc    = idle && lk_valid && hit;
  assign start_miss = idle && lk_valid && !hit;
  assign rf_req_valid = (st_q == FS_REQ);
  assign rsp_take   = (st_q == FS_WAIT) && rf_rsp_valid;
  assign stale      = drop_q || flush;
  assign install    = rsp_take && !rf_rsp_fault && !stale;
  assign fault_rep  = rsp_take && rf_rsp_fault && !stale;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      FS_IDLE: if (start_miss)   st_nx = FS_REQ;
      FS_REQ:  if (rf_req_ready) st_nx = FS_WAIT;
      FS_WAIT: if (rf_rsp_valid) st_nx = FS_IDLE;
      default:                   st_nx = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      drop_q <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (start_miss)          drop_q <= 1'b0;
      else if (!idle && flush) drop_q <= 1'b1;
    end
  end

endmodule

// File: rtl/utlb.sv
module utlb
  import utlb_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int FLAG_W = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              res_valid,
  output logic              res_fault,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [FLAG_W-1:0] res_flags,
  output logic              rf_req_valid,
  input  logic              rf_req_ready,
  output logic [VPN_W-1:0]  rf_req_vpn,
  output logic [ASID_W-1:0] rf_req_asid,
  input  logic              rf_rsp_valid,
  input  logic              rf_rsp_fault,
  input  logic [PFN_W-1:0]  rf_rsp_pfn,
  input  logic [FLAG_W-1:0] rf_rsp_flags,
  input  logic              rf_rsp_global,
  input  logic [2:0]        mt_cmd
);

  logic [WAYS-1:0]        ent_valid, ent_global;
  logic [WAYS*VPN_W-1:0]  ent_vpn;
  logic [WAYS*ASID_W-1:0] ent_asid;
  logic [WAYS*PFN_W-1:0]  ent_pfn;
  logic [WAYS*FLAG_W-1:0] ent_flags;

  logic [VPN_W-1:0]  pend_vpn;
  logic [ASID_W-1:0] pend_asid;

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_idx, plru_idx, fill_idx, touch_idx;
  logic             flush, hit_acc, start_miss, install, fault_rep, busy, touch;

  assign flush = cmd_clears(mt_cmd);

  utlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .ent_valid (ent_valid),
    .ent_global(ent_global),
    .ent_vpn   (ent_vpn),
    .ent_asid  (ent_asid),
    .q_vpn     (lk_vpn),
    .q_asid    (lk_asid),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  utlb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .hit         (hit),
    .flush       (flush),
    .rf_req_ready(rf_req_ready),
    .rf_rsp_valid(rf_rsp_valid),
    .rf_rsp_fault(rf_rsp_fault),
    .rf_req_valid(rf_req_valid),
    .hit_acc     (hit_acc),
    .start_miss  (start_miss),
    .install     (install),
    .fault_rep   (fault_rep),
    .busy        (busy)
  );

  assign touch     = hit_acc || install;
  assign touch_idx = hit_acc ? hit_idx : fill_idx;

  utlb_plru #(.WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .victim_idx(plru_idx)
  );

  // Lowest-indexed free way, else the pseudo-LRU choice.
  always_comb begin
    fill_idx = plru_idx;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!ent_valid[i]) fill_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vpn  <= '0;
      pend_asid <= '0;
    end else if (start_miss) begin
      pend_vpn  <= lk_vpn;
      pend_asid <= lk_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (flush) begin
      ent_valid <= '0;
    end else if (install) begin
      ent_valid[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      ent_global[fill_idx]                <= rf_rsp_global;
      ent_vpn[fill_idx*VPN_W +: VPN_W]    <= pend_vpn;
      ent_asid[fill_idx*ASID_W +: ASID_W] <= pend_asid;
      ent_pfn[fill_idx*PFN_W +: PFN_W]    <= rf_rsp_pfn;
      ent_flags[fill_idx*FLAG_W +: FLAG_W] <= rf_rsp_flags;
    end
  end

  always_comb begin
    res_pfn   = '0;
    res_flags = '0;
    if (hit_acc) begin
      for (int i = 0; i < WAYS; i++) begin
        if (hit_vec[i]) begin
          res_pfn   = res_pfn | ent_pfn[i*PFN_W +: PFN_W];
          res_flags = res_flags | ent_flags[i*FLAG_W +: FLAG_W];
        end
      end
    end
  end

  assign lk_ready    = hit_acc || fault_rep;
  assign res_valid   = hit_acc || fault_rep;
  assign res_fault   = fault_rep;
  assign rf_req_vpn  = pend_vpn;
  assign rf_req_asid = pend_asid;

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              res_valid,
  input logic              res_fault,
  input logic              rf_req_valid,
  input logic              rf_req_ready,
  input logic [VPN_W-1:0]  rf_req_vpn,
  input logic [ASID_W-1:0] rf_req_asid,
  input logic [2:0]        mt_cmd,
  input logic [WAYS-1:0]   ent_valid,
  input logic [WAYS-1:0]   hit_vec,
  input logic              install
);

  // R1: a result only appears as the handshake of a presented lookup
  a_r1_result_is_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (lk_valid && lk_ready));

  // R1: acceptance always carries a result
  a_r1_accept_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |-> res_valid);

  // R3: refill request held stable under back-pressure
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !rf_req_ready) |=> (rf_req_valid && $stable(rf_req_vpn) && $stable(rf_req_asid)));

  // R3: lookup stalled while a refill is requested
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid |-> !lk_ready);

  // R5: never more than one way matches
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6, R8: clearing commands empty the array
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_cmd == 3'd1 || mt_cmd == 3'd3) |=> (ent_valid == '0));

  // R7: non-invalidating write leaves entries alone
  a_r7_keep_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_cmd == 3'd2 && !install) |=> $stable(ent_valid));

  // R10: a fault is always a result
  a_r10_fault_is_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_valid);

endmodule

bind utlb utlb_chk #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .res_valid   (res_valid),
  .res_fault   (res_fault),
  .rf_req_valid(rf_req_valid),
  .rf_req_ready(rf_req_ready),
  .rf_req_vpn  (rf_req_vpn),
  .rf_req_asid (rf_req_asid),
  .mt_cmd      (mt_cmd),
  .ent_valid   (ent_valid),
  .hit_vec     (hit_vec),
  .install     (install)
);

// File: tb/tb_utlb.sv
module tb_utlb;

  localparam int WAYS = 4, VPN_W = 20, PFN_W = 20, ASID_W = 8, FLAG_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic res_valid, res_fault;
  logic [PFN_W-1:0] res_pfn;
  logic [FLAG_W-1:0] res_flags;
  logic rf_req_valid, rf_req_ready = 1'b0;
  logic [VPN_W-1:0] rf_req_vpn;
  logic [ASID_W-1:0] rf_req_asid;
  logic rf_rsp_valid = 1'b0, rf_rsp_fault = 1'b0, rf_rsp_global = 1'b0;
  logic [PFN_W-1:0] rf_rsp_pfn = '0;
  logic [FLAG_W-1:0] rf_rsp_flags = '0;
  logic [2:0] mt_cmd = 3'd0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  utlb #(.WAYS(WAYS), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .FLAG_W(FLAG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .res_valid(res_valid), .res_fault(res_fault), .res_pfn(res_pfn), .res_flags(res_flags),
    .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready),
    .rf_req_vpn(rf_req_vpn), .rf_req_asid(rf_req_asid),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_fault(rf_rsp_fault), .rf_rsp_pfn(rf_rsp_pfn),
    .rf_rsp_flags(rf_rsp_flags), .rf_rsp_global(rf_rsp_global),
    .mt_cmd(mt_cmd)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Miss, refill successfully, then observe the hit.
  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input logic [FLAG_W-1:0] f,
                      input logic g, input string req);
    @(negedge clk); lk_valid = 1; lk_vpn = v; lk_asid = a;
    #5 chk(req, "miss not accepted", lk_ready, 0);
    @(negedge clk); #5;
    chk(req, "R3 request valid", rf_req_valid, 1);
    chk(req, "R3 request page", rf_req_vpn, v);
    chk(req, "R3 request asid", rf_req_asid, a);
    rf_req_ready = 1;
    @(negedge clk); rf_req_ready = 0;
    rf_rsp_valid = 1; rf_rsp_fault = 0; rf_rsp_pfn = p; rf_rsp_flags = f; rf_rsp_global = g;
    #5 chk(req, "stalled in response cycle", lk_ready, 0);
    @(negedge clk); rf_rsp_valid = 0;
    #5 chk(req, "R4 hit after install", lk_ready, 1);
    chk(req, "R4 installed frame", res_pfn, p);
    chk(req, "R4 installed flags", res_flags, f);
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic probe_hit(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                           input logic [PFN_W-1:0] p, input logic [FLAG_W-1:0] f, input string req);
    @(negedge clk); lk_valid = 1; lk_vpn = v; lk_asid = a;
    #5 chk(req, "hit accepted", lk_ready, 1);
    chk(req, "hit result valid", res_valid, 1);
    chk(req, "hit no fault", res_fault, 0);
    chk(req, "hit frame", res_pfn, p);
    chk(req, "hit flags", res_flags, f);
    @(negedge clk); lk_valid = 0;
  endtask

  // Expect a miss; close the refill with a fault response (R10).
  task automatic miss_fault(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input string req);
    @(negedge clk); lk_valid = 1; lk_vpn = v; lk_asid = a;
    #5 chk(req, "expected miss", lk_ready, 0);
    @(negedge clk); #5;
    chk(req, "refill requested", rf_req_valid, 1);
    rf_req_ready = 1;
    @(negedge clk); rf_req_ready = 0; rf_rsp_valid = 1; rf_rsp_fault = 1;
    #5 chk("R10", "fault accepted", lk_ready, 1);
    chk("R10", "fault result valid", res_valid, 1);
    chk("R10", "fault flag", res_fault, 1);
    @(negedge clk); rf_rsp_valid = 0; rf_rsp_fault = 0; lk_valid = 0;
  endtask

  task automatic issue_cmd(input logic [2:0] c);
    @(negedge clk); mt_cmd = c;
    @(negedge clk); mt_cmd = 3'd0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R11", "no request after reset", rf_req_valid, 0);
    chk("R11", "not ready idle", lk_ready, 0);
    chk("R11", "no result idle", res_valid, 0);
    rst_n = 1;
    miss_fault(20'h00010, 8'h05, "R11");
  endtask

  task automatic t_asid;
    fill(20'h00100, 8'h05, 20'hA0100, 4'h3, 1'b0, "R4");
    probe_hit(20'h00100, 8'h05, 20'hA0100, 4'h3, "R1");
    miss_fault(20'h00100, 8'h06, "R2");
    fill(20'h00200, 8'h05, 20'hB0200, 4'h9, 1'b1, "R2");
    probe_hit(20'h00200, 8'h77, 20'hB0200, 4'h9, "R2");
  endtask

  task automatic t_keep;
    issue_cmd(3'd2);
    issue_cmd(3'd0);
    issue_cmd(3'd5);
    issue_cmd(3'd7);
    probe_hit(20'h00100, 8'h05, 20'hA0100, 4'h3, "R7");
    probe_hit(20'h00200, 8'h01, 20'hB0200, 4'h9, "R7");
  endtask

  task automatic t_flush_write;
    issue_cmd(3'd1);
    miss_fault(20'h00100, 8'h05, "R6");
    miss_fault(20'h00200, 8'h05, "R6");
  endtask

  task automatic t_inval;
    fill(20'h00300, 8'h02, 20'hC0300, 4'h1, 1'b0, "R8");
    issue_cmd(3'd3);
    miss_fault(20'h00300, 8'h02, "R8");
  endtask

  task automatic t_victim;
    issue_cmd(3'd3);
    fill(20'h01000, 8'h01, 20'h11000, 4'h1, 1'b0, "R4");
    fill(20'h02000, 8'h01, 20'h12000, 4'h2, 1'b0, "R4");
    fill(20'h03000, 8'h01, 20'h13000, 4'h3, 1'b0, "R4");
    fill(20'h04000, 8'h01, 20'h14000, 4'h4, 1'b0, "R4");
    probe_hit(20'h01000, 8'h01, 20'h11000, 4'h1, "R4");
    probe_hit(20'h02000, 8'h01, 20'h12000, 4'h2, "R4");
    probe_hit(20'h03000, 8'h01, 20'h13000, 4'h3, "R4");
    probe_hit(20'h04000, 8'h01, 20'h14000, 4'h4, "R4");
    // Last touches 1,2,3,4 then 1: tree now names the third page's way.
    probe_hit(20'h01000, 8'h01, 20'h11000, 4'h1, "R5");
    fill(20'h05000, 8'h01, 20'h15000, 4'h5, 1'b0, "R5");
    probe_hit(20'h01000, 8'h01, 20'h11000, 4'h1, "R5");
    probe_hit(20'h02000, 8'h01, 20'h12000, 4'h2, "R5");
    probe_hit(20'h04000, 8'h01, 20'h14000, 4'h4, "R5");
    miss_fault(20'h03000, 8'h01, "R5");
  endtask

  task automatic t_inval_in_flight;
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h06000; lk_asid = 8'h04;
    @(negedge clk); mt_cmd = 3'd3;
    #5 chk("R9", "request pending", rf_req_valid, 1);
    rf_req_ready = 1;
    @(negedge clk); mt_cmd = 3'd0; rf_req_ready = 0;
    rf_rsp_valid = 1; rf_rsp_pfn = 20'h16000; rf_rsp_flags = 4'h6;
    #5 chk("R9", "discarded response not accepted", lk_ready, 0);
    chk("R9", "discarded response no result", res_valid, 0);
    @(negedge clk); rf_rsp_valid = 0;
    #5 chk("R9", "still missing after discard", lk_ready, 0);
    @(negedge clk); #5;
    chk("R9", "new refill issued", rf_req_valid, 1);
    rf_req_ready = 1;
    @(negedge clk); rf_req_ready = 0; rf_rsp_valid = 1; rf_rsp_fault = 1;
    #5 chk("R10", "fault closes retry", res_fault, 1);
    @(negedge clk); rf_rsp_valid = 0; rf_rsp_fault = 0; lk_valid = 0;
    miss_fault(20'h06000, 8'h04, "R9");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_asid();
    t_keep();
    t_flush_write();
    t_inval();
    t_victim();
    t_inval_in_flight();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule